// File: doc/BRIEF.md
# Queued Offer Bus Arbiter

This block lets four bus masters share one slave through tentative offers. A master asks for the bus by raising its cycle line with strobe low. The offer binds the master to nothing. The arbiter keeps the offers in a queue, ordered by when they arrived. Every master that is waiting sees its stall line held high. When the current owner lowers its cycle line, the master at the head of the queue becomes the owner on that same clock edge. The new owner may then run its transfer, usually with lock asserted. It keeps the bus until it lowers its own cycle line.

A master can withdraw its offer by lowering its cycle line before it is granted. When it does, the arbiter throws away that queue position and every position behind it. Masters ahead of it keep their places. A master that was thrown out this way but still holds its cycle line high gets an error response, which tells it to give up the offer. Only the owner's strobe, write enable, lock, address and write data reach the slave. The slave's ack goes back to the owner only, and the owner's stall line follows the slave's pipeline stall.

Top module: `offer_arbiter`

## Requirements
- R1: Masters that raise their cycle line in the same cycle join the queue tail in ascending index order. Masters that raise it in different cycles are granted in arrival order.
- R2: When there is no owner and the queue is empty, a master that raises its cycle line owns the bus after exactly one clock edge.
- R3: A master with its cycle line high that is not the owner sees its stall output high.
- R4: The owner's stall output equals the slave stall input.
- R5: On the edge where the owner's cycle line is sampled low, the queue head becomes the owner. If the queue is empty, the bus goes idle.
- R6: When a queued master lowers its cycle line, its own queue entry is removed, along with all entries behind it. Entries ahead of it keep their order.
- R7: A master removed from the queue by someone else's withdrawal sees its error output high from the next cycle for as long as its cycle line stays high. It is not queued again until it has lowered its cycle line. The owner never sees error.
- R8: The owner keeps the bus while its cycle line is high, whatever the other masters do.
- R9: The slave outputs carry only the owner's signals. The slave outputs are all zero when there is no owner. Ack is returned only to the owner.
- R10: A master is never queued twice. A master that holds its offer for many cycles is granted once.
- R11: A synchronous active-low reset empties the queue, clears ownership and clears the error state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| m_cyc | input | NUM_MST | Cycle (offer / ownership) line per master |
| m_stb | input | NUM_MST | Strobe per master |
| m_we | input | NUM_MST | Write enable per master |
| m_lock | input | NUM_MST | Lock per master |
| m_adr | input | NUM_MST*AW | Addresses, master i at bits i*AW |
| m_wdat | input | NUM_MST*DW | Write data, master i at bits i*DW |
| m_stall | output | NUM_MST | Stall per master |
| m_ack | output | NUM_MST | Ack per master |
| m_err | output | NUM_MST | Error (offer rejected) per master |
| m_rdat | output | DW | Read data broadcast to all masters |
| s_cyc | output | 1 | Cycle to slave |
| s_stb | output | 1 | Strobe to slave |
| s_we | output | 1 | Write enable to slave |
| s_lock | output | 1 | Lock to slave |
| s_adr | output | AW | Address to slave |
| s_wdat | output | DW | Write data to slave |
| s_rdat | input | DW | Read data from slave |
| s_ack | input | 1 | Ack from slave |
| s_stall | input | 1 | Pipeline stall from slave |

## Verification
The hardest state to reach is a withdrawal from the middle of a queue that is at least three deep. That needs an owner busy long enough for others to pile up. It also needs the master behind the withdrawing one to still hold its offer, so that an error shows. A directed sequence builds this state. Master 0 holds the bus while masters 2, 3 and 1 offer one after another. Master 3 then withdraws, and the bench checks the error on master 1 and the later grant of master 2. Random traffic with long ownership and rare withdrawals then revisits these states. A bench model predicts stall, error, ack and slave outputs on every cycle.

// File: rtl/arb_pkg.sv
// Shared types for the queued offer arbiter.
// Assumes no more than 16 masters, so one master index fits in 4 bits.
package arb_pkg;
    localparam int unsigned ARB_ID_W = 4;
    typedef logic [ARB_ID_W-1:0] mst_id_t;
endpackage

// File: rtl/offer_queue.sv
// Ordered queue of pending offers. Each cycle it removes the entries cut
// by a withdrawal, adds new offers in ascending index order, and pops the
// head when the bus is free. It produces the grant and a mask of masters
// that were cut out of the queue while still holding their cycle line.
// Assumes the caller blocks owner and rejected masters from offering.
module offer_queue
    import arb_pkg::*;
#(
    parameter int unsigned NUM_MST = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_MST-1:0] cyc,
    input  logic [NUM_MST-1:0] blocked,
    input  logic               bus_free,
    output logic               grant_vld,
    output mst_id_t            grant_idx,
    output logic [NUM_MST-1:0] drop_mask
);
    localparam int unsigned LW = $clog2(NUM_MST + 1);

    mst_id_t            q_id [NUM_MST];
    logic [LW-1:0]      q_len;
    mst_id_t            e_id [NUM_MST];
    logic [LW-1:0]      e_len;
    logic [NUM_MST-1:0] queued;
    logic [NUM_MST-1:0] slot_live;
    logic [NUM_MST-1:0] slot_cyc;
    logic [LW-1:0]      cut;
    logic               cut_found;

    // Decode which masters hold a live slot, and each slot's cycle line.
    always_comb begin
        queued    = '0;
        slot_cyc  = '0;
        slot_live = '0;
        for (int k = 0; k < NUM_MST; k++) begin
            slot_live[k] = LW'(k) < q_len;
            for (int i = 0; i < NUM_MST; i++) begin
                if (q_id[k] == mst_id_t'(i)) begin
                    slot_cyc[k] = cyc[i];
                    if (slot_live[k]) queued[i] = 1'b1;
                end
            end
        end
    end

    // Find the first withdrawn slot and the masters cut behind it.
    always_comb begin
        cut       = q_len;
        cut_found = 1'b0;
        drop_mask = '0;
        for (int k = 0; k < NUM_MST; k++) begin
            if (!cut_found && slot_live[k] && !slot_cyc[k]) begin
                cut       = LW'(k);
                cut_found = 1'b1;
            end
        end
        for (int k = 0; k < NUM_MST; k++) begin
            if (slot_live[k] && LW'(k) > cut) begin
                for (int i = 0; i < NUM_MST; i++)
                    if (q_id[k] == mst_id_t'(i) && cyc[i]) drop_mask[i] = 1'b1;
            end
        end
    end

    // Build the next order: the kept prefix, then new offers by index.
    always_comb begin
        e_id  = q_id;
        e_len = cut;
        for (int i = 0; i < NUM_MST; i++) begin
            if (cyc[i] && !queued[i] && !blocked[i]) begin
                for (int k = 0; k < NUM_MST; k++)
                    if (LW'(k) == e_len) e_id[k] = mst_id_t'(i);
                e_len = e_len + LW'(1);
            end
        end
        grant_vld = bus_free && (e_len != '0);
        grant_idx = e_id[0];
    end

    // Store the new order, popping the head when it is granted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_len <= '0;
            for (int k = 0; k < NUM_MST; k++) q_id[k] <= '0;
        end else if (grant_vld) begin
            for (int k = 0; k < NUM_MST - 1; k++) q_id[k] <= e_id[k+1];
            q_id[NUM_MST-1] <= '0;
            q_len           <= e_len - LW'(1);
        end else begin
            q_id  <= e_id;
            q_len <= e_len;
        end
    end

    // R10
    queue_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(queued) == int'(q_len));

    // R10
    queue_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(q_len) <= NUM_MST);
endmodule

// File: rtl/bus_route.sv
// Connects the owner to the slave, and routes stall and ack per master.
// Assumes owner_idx is meaningful only while owner_vld is high.
module bus_route
    import arb_pkg::*;
#(
    parameter int unsigned NUM_MST = 4,
    parameter int unsigned AW      = 32,
    parameter int unsigned DW      = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  owner_vld,
    input  mst_id_t               owner_idx,
    input  logic [NUM_MST-1:0]    m_cyc,
    input  logic [NUM_MST-1:0]    m_stb,
    input  logic [NUM_MST-1:0]    m_we,
    input  logic [NUM_MST-1:0]    m_lock,
    input  logic [NUM_MST*AW-1:0] m_adr,
    input  logic [NUM_MST*DW-1:0] m_wdat,
    output logic [NUM_MST-1:0]    m_stall,
    output logic [NUM_MST-1:0]    m_ack,
    output logic                  s_cyc,
    output logic                  s_stb,
    output logic                  s_we,
    output logic                  s_lock,
    output logic [AW-1:0]         s_adr,
    output logic [DW-1:0]         s_wdat,
    input  logic                  s_ack,
    input  logic                  s_stall
);
    logic [NUM_MST-1:0] is_own;

    // One-hot decode of the owner.
    always_comb begin
        for (int i = 0; i < NUM_MST; i++)
            is_own[i] = owner_vld && (owner_idx == mst_id_t'(i));
    end

    // Pass only the owner's request fields to the slave.
    always_comb begin
        s_cyc  = 1'b0;
        s_stb  = 1'b0;
        s_we   = 1'b0;
        s_lock = 1'b0;
        s_adr  = '0;
        s_wdat = '0;
        for (int i = 0; i < NUM_MST; i++) begin
            if (is_own[i]) begin
                s_cyc  = m_cyc[i];
                s_stb  = m_cyc[i] & m_stb[i];
                s_we   = m_we[i];
                s_lock = m_lock[i];
                s_adr  = m_adr[i*AW +: AW];
                s_wdat = m_wdat[i*DW +: DW];
            end
        end
    end

    // Waiting masters are stalled; the owner sees the slave's stall.
    always_comb begin
        for (int i = 0; i < NUM_MST; i++) begin
            m_stall[i] = is_own[i] ? s_stall : m_cyc[i];
            m_ack[i]   = is_own[i] & m_cyc[i] & s_ack;
        end
    end

    // R9
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(m_ack));

    // R9
    idle_slave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !owner_vld |-> (!s_stb && !s_cyc));
endmodule

// File: rtl/offer_arbiter.sv
// Top of the queued offer arbiter. It holds the bus owner and the error
// state of masters that were cut out of the queue. Queue order is kept
// in offer_queue, and slave routing is done in bus_route.
// Assumes NUM_MST <= 16, and that masters keep strobe low until granted.
module offer_arbiter
    import arb_pkg::*;
#(
    parameter int unsigned NUM_MST = 4,
    parameter int unsigned AW      = 32,
    parameter int unsigned DW      = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_MST-1:0]    m_cyc,
    input  logic [NUM_MST-1:0]    m_stb,
    input  logic [NUM_MST-1:0]    m_we,
    input  logic [NUM_MST-1:0]    m_lock,
    input  logic [NUM_MST*AW-1:0] m_adr,
    input  logic [NUM_MST*DW-1:0] m_wdat,
    output logic [NUM_MST-1:0]    m_stall,
    output logic [NUM_MST-1:0]    m_ack,
    output logic [NUM_MST-1:0]    m_err,
    output logic [DW-1:0]         m_rdat,
    output logic                  s_cyc,
    output logic                  s_stb,
    output logic                  s_we,
    output logic                  s_lock,
    output logic [AW-1:0]         s_adr,
    output logic [DW-1:0]         s_wdat,
    input  logic [DW-1:0]         s_rdat,
    input  logic                  s_ack,
    input  logic                  s_stall
);
    logic               owner_vld;
    mst_id_t            owner_idx;
    logic [NUM_MST-1:0] owner_mask;
    logic               owner_cyc;
    logic               bus_free;
    logic [NUM_MST-1:0] rejected;
    logic [NUM_MST-1:0] drop_mask;
    logic               grant_vld;
    mst_id_t            grant_idx;

    // Owner decode and its cycle line.
    always_comb begin
        owner_cyc = 1'b0;
        for (int i = 0; i < NUM_MST; i++) begin
            owner_mask[i] = owner_vld && (owner_idx == mst_id_t'(i));
            if (owner_mask[i]) owner_cyc = m_cyc[i];
        end
        bus_free = !owner_vld || !owner_cyc;
    end

    offer_queue #(.NUM_MST(NUM_MST)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc       (m_cyc),
        .blocked   (rejected | owner_mask),
        .bus_free  (bus_free),
        .grant_vld (grant_vld),
        .grant_idx (grant_idx),
        .drop_mask (drop_mask)
    );

    // Ownership passes to the granted head, or is released when free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_vld <= 1'b0;
            owner_idx <= '0;
        end else if (grant_vld) begin
            owner_vld <= 1'b1;
            owner_idx <= grant_idx;
        end else if (bus_free) begin
            owner_vld <= 1'b0;
        end
    end

    // Rejected state holds until the master lowers its cycle line.
    always_ff @(posedge clk) begin
        if (!rst_n) rejected <= '0;
        else        rejected <= (rejected & m_cyc) | drop_mask;
    end

    assign m_err  = rejected & m_cyc;
    assign m_rdat = s_rdat;

    bus_route #(.NUM_MST(NUM_MST), .AW(AW), .DW(DW)) u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .owner_vld (owner_vld),
        .owner_idx (owner_idx),
        .m_cyc     (m_cyc),
        .m_stb     (m_stb),
        .m_we      (m_we),
        .m_lock    (m_lock),
        .m_adr     (m_adr),
        .m_wdat    (m_wdat),
        .m_stall   (m_stall),
        .m_ack     (m_ack),
        .s_cyc     (s_cyc),
        .s_stb     (s_stb),
        .s_we      (s_we),
        .s_lock    (s_lock),
        .s_adr     (s_adr),
        .s_wdat    (s_wdat),
        .s_ack     (s_ack),
        .s_stall   (s_stall)
    );

    // R8
    owner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_vld && owner_cyc) |=> (owner_vld && owner_idx == $past(owner_idx)));

    // R7
    err_not_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_err & owner_mask) == '0);

    // R3
    waiter_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_cyc & ~owner_mask & ~m_stall) == '0);
endmodule

// File: tb/offer_arbiter_bench.sv
`timescale 1ns/1ps
module offer_arbiter_bench;
    localparam int N  = 4;
    localparam int AW = 16;
    localparam int DW = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    m_cyc = '0, m_stb = '0, m_we = '0, m_lock = '0;
    logic [N*AW-1:0] m_adr;
    logic [N*DW-1:0] m_wdat = '0;
    logic [N-1:0]    m_stall, m_ack, m_err;
    logic [DW-1:0]   m_rdat;
    logic            s_cyc, s_stb, s_we, s_lock;
    logic [AW-1:0]   s_adr;
    logic [DW-1:0]   s_wdat;
    logic [DW-1:0]   s_rdat = '0;
    logic            s_ack = 1'b0, s_stall = 1'b0;

    int checks = 0;
    int fails  = 0;

    // reference model state
    int     mq[N];
    int     mlen = 0;
    int     mown = 0;
    bit     mown_v = 0;
    bit [N-1:0] mdrp = '0;

    always #10 clk = ~clk;

    for (genvar g = 0; g < N; g++) begin : g_adr
        assign m_adr[g*AW +: AW] = AW'(16'hA000 + g);
    end

    offer_arbiter #(.NUM_MST(N), .AW(AW), .DW(DW)) u_offer_arbiter (
        .clk(clk), .rst_n(rst_n), .m_cyc(m_cyc), .m_stb(m_stb), .m_we(m_we),
        .m_lock(m_lock), .m_adr(m_adr), .m_wdat(m_wdat), .m_stall(m_stall),
        .m_ack(m_ack), .m_err(m_err), .m_rdat(m_rdat), .s_cyc(s_cyc),
        .s_stb(s_stb), .s_we(s_we), .s_lock(s_lock), .s_adr(s_adr),
        .s_wdat(s_wdat), .s_rdat(s_rdat), .s_ack(s_ack), .s_stall(s_stall));

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic bit is_owner(input int i);
        return mown_v && mown == i;
    endfunction

    // compare all outputs against the model for the current cycle
    task automatic compare_all();
        bit exp_cyc;
        exp_cyc = mown_v && m_cyc[mown];
        for (int i = 0; i < N; i++) begin
            if (is_owner(i)) chk("R4", "owner stall", m_stall[i], s_stall);
            else             chk("R3", "waiter stall", m_stall[i], m_cyc[i]);
            chk("R7", "err", m_err[i], mdrp[i] && m_cyc[i]);
            chk("R9", "ack", m_ack[i], is_owner(i) && m_cyc[i] && s_ack);
        end
        chk("R9", "s_cyc", s_cyc, exp_cyc);
        chk("R9", "s_stb", s_stb, exp_cyc && m_stb[mown]);
        chk("R9", "s_adr", s_adr, mown_v ? int'(16'hA000 + mown) : 0);
    endtask

    // next model state from the requirements
    task automatic model_step();
        int cut, elen;
        bit found, free;
        int eq[N];
        bit [N-1:0] ndrp, queued;
        if (!rst_n) begin
            mlen = 0; mown_v = 0; mdrp = '0;
            return;
        end
        cut = mlen; found = 0;
        for (int k = 0; k < mlen; k++)
            if (!found && !m_cyc[mq[k]]) begin cut = k; found = 1; end
        ndrp = mdrp & m_cyc;
        for (int k = cut + 1; k < mlen; k++)
            if (m_cyc[mq[k]]) ndrp[mq[k]] = 1'b1;
        queued = '0;
        for (int k = 0; k < mlen; k++) queued[mq[k]] = 1'b1;
        eq = mq; elen = cut;
        for (int i = 0; i < N; i++)
            if (m_cyc[i] && !queued[i] && !mdrp[i] && !is_owner(i)) begin
                eq[elen] = i; elen++;
            end
        free = !mown_v || !m_cyc[mown];
        if (free && elen > 0) begin
            mown = eq[0]; mown_v = 1;
            for (int k = 0; k < N - 1; k++) eq[k] = eq[k+1];
            elen--;
        end else if (free) mown_v = 0;
        mq = eq; mlen = elen; mdrp = ndrp;
    endtask

    task automatic tick();
        @(negedge clk);
        if (rst_n) compare_all();
        model_step();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_owner(input string req, input int idx);
        chk(req, "owner s_cyc", s_cyc, 1);
        chk(req, "owner s_adr", s_adr, 16'hA000 + idx);
    endtask

    initial begin : watchdog
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd4242));
        repeat (3) tick();
        rst_n = 1'b1;
        #1;
        // R11 reset state
        chk("R11", "stall after reset", m_stall, 0);
        chk("R11", "err after reset", m_err, 0);
        chk("R11", "s_cyc after reset", s_cyc, 0);

        // R2 idle grant after one edge
        m_cyc[0] = 1; tick();
        expect_owner("R2", 0);
        chk("R2", "stall low", m_stall[0], 0);
        m_stb[0] = 1; m_lock[0] = 1;
        m_cyc[2] = 1; tick();
        m_cyc[3] = 1; tick();
        m_cyc[1] = 1; tick();
        repeat (4) begin tick(); expect_owner("R8", 0); end
        chk("R3", "queued stalls", m_stall[3:1], 3'b111);
        // R6 master 3 withdraws, master 1 is cut
        m_cyc[3] = 0; tick();
        chk("R7", "cut master err", m_err[1], 1);
        chk("R6", "ahead still waiting", m_stall[2], 1);
        chk("R6", "ahead no err", m_err[2], 0);
        m_cyc[0] = 0; m_stb[0] = 0; m_lock[0] = 0; tick();
        expect_owner("R5", 2);
        chk("R7", "err persists", m_err[1], 1);
        m_cyc[1] = 0; tick();
        chk("R7", "err clears", m_err[1], 0);
        // R1 same-cycle offers in ascending index
        m_cyc[3] = 1; m_cyc[1] = 1; tick();
        tick();
        m_cyc[2] = 0; tick();
        expect_owner("R1", 1);
        m_cyc[1] = 0; tick();
        expect_owner("R1", 3);
        // R10 long-held offer granted once
        m_cyc[0] = 1; repeat (6) tick();
        m_cyc[3] = 0; tick();
        expect_owner("R10", 0);
        m_cyc[0] = 0; tick();
        chk("R10", "bus idle after single grant", s_cyc, 0);
        chk("R5", "idle with empty queue", m_stall, 0);

        // random traffic
        for (int c = 0; c < 4000; c++) begin
            for (int i = 0; i < N; i++) begin
                if (!m_cyc[i]) begin
                    if ($urandom_range(4) == 0) begin m_cyc[i] = 1; m_stb[i] = 0; end
                end else if (is_owner(i)) begin
                    m_stb[i] = 1'($urandom);
                    m_we[i] = 1'($urandom);
                    m_lock[i] = 1;
                    if ($urandom_range(7) == 0) begin
                        m_cyc[i] = 0; m_stb[i] = 0; m_lock[i] = 0;
                    end
                end else if (mdrp[i]) begin
                    m_cyc[i] = 0;
                end else if ($urandom_range(24) == 0) begin
                    m_cyc[i] = 0;
                end
            end
            m_wdat  = (N*DW)'({$urandom, $urandom});
            s_ack   = 1'($urandom);
            s_stall = ($urandom_range(3) == 0);
            s_rdat  = DW'($urandom);
            if (c == 2500) rst_n = 0;
            if (c == 2503) rst_n = 1;
            tick();
            if (!rst_n) begin
                chk("R11", "stall in reset", m_stall & ~m_cyc, 0);
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule